// File: doc/BRIEF.md
# Transactional Conflict Resolution Arbiter

This block settles coherence conflicts between hardware transactions. A transaction that asks for a line presents its ID, its start age stamp and whether it wants to read or write. The directory side supplies, next to the request, the set of transactions that currently hold the line, with each holder's age stamp and a flag for holders that have the line in their write set. One cycle after the request is accepted, the arbiter answers with one of three outcomes: grant, stall, or abort the requester. It also returns a mask of holders that must be aborted.

The policy merges four rules. Under the age rule, a strictly older requester wins and a younger one waits. A writer that has waited too long behind readers gets an override. Two transactions that both try to upgrade the same line are split by age. Each aborted transaction gets an exponential back-off window, and while that window is open its requests are refused.

For the lazy side, a single commit token is passed among committing transactions. When the token owner reports that its commit has finished, the transactions it conflicted with are aborted. A transaction that has been aborted often gets priority for the token. Age stamps are assigned outside the block and are kept across retries.

Top module: `txn_arbiter`

## Requirements
- R1: A request with no conflicting holder is granted with an empty abort mask. A conflict exists with a valid holder other than the requester itself when the request is a write or the holder is a writer. Two readers never conflict.
- R2: When a conflict exists and the requester's age stamp is strictly smaller than that of every conflicting holder, the request is granted and every conflicting holder is in the abort mask. In all other cases the requester stalls with an empty mask, and an equal stamp counts as not older. Exceptions are R4 and R5.
- R3: A request is accepted when req_valid and req_ready are both high. One cycle later dec_valid is high with dec_id equal to the accepted ID. The encoding of dec_kind is 0 grant, 1 stall, 2 abort-self. req_ready is low while the requester's back-off window is open.
- R4: A write that stalled keeps the requester waiting. New readers may still join the holder set. Once it has waited STARVE_LIMIT cycles and every conflicting holder is a reader, its next request is granted and all those readers are aborted. A grant clears the alarm, so a request right after it follows R2 again.
- R5: A dueling upgrade arises when a requester that holds the line asks to write and a conflicting reader is itself a stalled writer. If any such upgrader is older than the requester, the outcome is abort-self with a mask of only the requester's bit. Otherwise the requester stalls and those younger upgraders are in the mask.
- R6: At most one transaction owns the commit token. A free token goes to the lowest-indexed requester. The owner keeps it until the cycle after its own commit_done, and commit_done from a non-owner has no effect.
- R7: When the owner signals commit_done, every transaction in commit_kill except the owner is pulsed on txn_abort in the next cycle. Every abort from a decision is pulsed on txn_abort in the same cycle as that decision.
- R8: A transaction whose abort count is at least PIN_ABORTS takes priority over all non-pinned requesters for a free token.
- R9: Each abort raises the transaction's abort count by one, saturating at its maximum. It then opens a back-off window lasting BACKOFF_BASE × 2^min(count, MAX_EXP) cycles plus a 0 to 15 cycle pseudo-random offset. A finished commit resets the count to zero.
- R10: After reset, dec_valid, txn_abort, token_grant and backoff_active are all zero and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (requester not backing off) |
| req_id | input | ID_W | Requesting transaction |
| req_ts | input | TS_W | Requester age stamp (smaller is older) |
| req_wr | input | 1 | 1 = write request, 0 = read |
| holder_valid | input | N_TXN | Transactions holding the line |
| holder_wr | input | N_TXN | Holder has the line in its write set |
| holder_ts | input | N_TXN*TS_W | Age stamp of each transaction, index i at bits i*TS_W |
| dec_valid | output | 1 | Decision present |
| dec_kind | output | 2 | 0 grant, 1 stall, 2 abort-self |
| dec_id | output | ID_W | Transaction the decision is for |
| dec_abort | output | N_TXN | Transactions aborted by this decision |
| txn_abort | output | N_TXN | Abort pulse per transaction |
| commit_req | input | N_TXN | Transaction asks for the commit token |
| commit_done | input | N_TXN | Transaction finished its commit |
| commit_kill | input | N_TXN | Transactions conflicting with the finishing committer |
| token_grant | output | N_TXN | One-hot commit token owner |
| backoff_active | output | N_TXN | Back-off window open per transaction |

## Verification
The bench targets ties in age stamps, which a design using a non-strict compare would wrongly grant. It checks that a requester's own holder entry is excluded, since without that exclusion every upgrade would stall on itself. It runs the starvation override both before and after the alarm, and again right after a grant, so a design that never clears the alarm would keep aborting readers. It drives dueling upgrades in both age directions, commit_done from a non-owner, a pinned transaction competing against a lower index, and back-off windows after one and two aborts and again after a commit. These expose a window that does not grow or never resets, and a token that moves when it should stay.

// File: rtl/txn_arb_pkg.sv
// Shared types for the transactional conflict arbiter.
package txn_arb_pkg;
    typedef enum logic [1:0] {
        DEC_GRANT      = 2'd0,
        DEC_STALL      = 2'd1,
        DEC_ABORT_SELF = 2'd2
    } dec_kind_e;
endpackage

// File: rtl/txn_conflict_policy.sv
// Combinational conflict policy: age rule, starvation override, dueling upgrade.
// Assumes a smaller age stamp means an older transaction; no wrap handling.
module txn_conflict_policy
    import txn_arb_pkg::*;
#(
    parameter int N_TXN = 4,
    parameter int TS_W  = 16,
    localparam int ID_W = $clog2(N_TXN)
) (
    input  logic [N_TXN-1:0]      hv,
    input  logic [N_TXN-1:0]      hw,
    input  logic [N_TXN*TS_W-1:0] hts,
    input  logic [ID_W-1:0]       req_id,
    input  logic [TS_W-1:0]       req_ts,
    input  logic                  req_wr,
    input  logic [N_TXN-1:0]      waiting,
    input  logic                  starved,
    output dec_kind_e             kind,
    output logic [N_TXN-1:0]      mask
);
    logic [N_TXN-1:0] conf, duel;
    logic older_all, all_rd, duel_older;

    // Classify every holder against the request.
    always_comb begin
        conf       = '0;
        duel       = '0;
        older_all  = 1'b1;
        all_rd     = 1'b1;
        duel_older = 1'b0;
        for (int i = 0; i < N_TXN; i++) begin
            if (hv[i] && (i != int'(req_id)) && (req_wr || hw[i])) begin
                conf[i] = 1'b1;
                if (!(req_ts < hts[i*TS_W +: TS_W])) older_all = 1'b0;
                if (hw[i]) all_rd = 1'b0;
                if (req_wr && hv[req_id] && waiting[i] && !hw[i]) begin
                    duel[i] = 1'b1;
                    if (hts[i*TS_W +: TS_W] < req_ts) duel_older = 1'b1;
                end
            end
        end
    end

    // Pick the outcome in priority order.
    always_comb begin
        if (conf == '0) begin
            kind = DEC_GRANT;
            mask = '0;
        end else if (older_all || (req_wr && starved && all_rd)) begin
            kind = DEC_GRANT;
            mask = conf;
        end else if (duel_older) begin
            kind = DEC_ABORT_SELF;
            mask = N_TXN'(1) << req_id;
        end else begin
            kind = DEC_STALL;
            mask = duel;
        end
    end
endmodule

// File: rtl/txn_starve_monitor.sv
// Tracks stalled writers and raises a per-transaction starvation alarm.
// Assumes a transaction has at most one outstanding write wait.
module txn_starve_monitor
    import txn_arb_pkg::*;
#(
    parameter int N_TXN        = 4,
    parameter int STARVE_LIMIT = 256,
    localparam int ID_W  = $clog2(N_TXN),
    localparam int CNT_W = $clog2(STARVE_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [ID_W-1:0]  req_id,
    input  logic             req_wr,
    input  dec_kind_e        kind,
    input  logic [N_TXN-1:0] abort_nxt,
    output logic [N_TXN-1:0] waiting,
    output logic [N_TXN-1:0] starved
);
    for (genvar i = 0; i < N_TXN; i++) begin : g_txn
        logic [CNT_W-1:0] cnt;
        logic set_w, clr_w;
        assign set_w = acc && (req_id == ID_W'(i)) && req_wr && (kind == DEC_STALL);
        assign clr_w = (acc && (req_id == ID_W'(i)) && (kind != DEC_STALL)) || abort_nxt[i];
        assign starved[i] = waiting[i] && (cnt >= CNT_W'(STARVE_LIMIT));

        // Wait flag and saturating stall-cycle counter.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_w) begin
                waiting[i] <= 1'b0;
                cnt        <= '0;
            end else if (set_w) begin
                waiting[i] <= 1'b1;
            end else if (waiting[i] && (cnt < CNT_W'(STARVE_LIMIT))) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/txn_commit_token.sv
// Single commit token; pinned transactions first, then lowest index.
// Assumes commit_kill is meaningful only with the owner's commit_done.
module txn_commit_token #(
    parameter int N_TXN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_TXN-1:0] commit_req,
    input  logic [N_TXN-1:0] commit_done,
    input  logic [N_TXN-1:0] commit_kill,
    input  logic [N_TXN-1:0] pinned,
    output logic [N_TXN-1:0] owner,
    output logic [N_TXN-1:0] kill,
    output logic [N_TXN-1:0] done_vec
);
    logic             owner_done;
    logic [N_TXN-1:0] cand, pick;

    assign owner_done = |(commit_done & owner);
    assign kill       = owner_done ? (commit_kill & ~owner) : '0;
    assign done_vec   = owner_done ? owner : '0;
    assign cand       = (|(commit_req & pinned)) ? (commit_req & pinned) : commit_req;
    assign pick       = cand & (~cand + 1'b1);

    // Hand out the token when free, release on the owner's commit.
    always_ff @(posedge clk) begin
        if (!rst_n || owner_done) owner <= '0;
        else if (owner == '0)     owner <= pick;
    end
endmodule

// File: rtl/txn_backoff.sv
// Per-transaction abort counter and exponential back-off timer with LFSR jitter.
// Assumes a commit and an abort of the same transaction never coincide.
module txn_backoff #(
    parameter int N_TXN        = 4,
    parameter int BACKOFF_BASE = 4,
    parameter int MAX_EXP      = 8,
    parameter int ABORT_W      = 4,
    parameter int PIN_ABORTS   = 3,
    localparam int TMR_W = $clog2((BACKOFF_BASE << MAX_EXP) + 16) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_TXN-1:0] abort_nxt,
    input  logic [N_TXN-1:0] clr_cnt,
    output logic [N_TXN-1:0] active,
    output logic [N_TXN-1:0] pinned
);
    logic [15:0] lfsr;

    // Free-running 16-bit Galois LFSR for jitter.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr <= 16'hACE1;
        else        lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
    end

    for (genvar i = 0; i < N_TXN; i++) begin : g_txn
        localparam int OFF = (i % 4) * 4;
        logic [ABORT_W-1:0] cnt, cnt_n;
        logic [ABORT_W-1:0] expo;
        logic [TMR_W-1:0]   tmr, load;

        assign cnt_n     = (cnt == '1) ? cnt : cnt + 1'b1;
        assign expo      = (cnt_n > ABORT_W'(MAX_EXP)) ? ABORT_W'(MAX_EXP) : cnt_n;
        assign load      = (TMR_W'(BACKOFF_BASE) << expo) + TMR_W'(lfsr[OFF +: 4]);
        assign active[i] = (tmr != '0);
        assign pinned[i] = (cnt >= ABORT_W'(PIN_ABORTS));

        // Count aborts, reload the window on abort, count it down otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
                tmr <= '0;
            end else if (clr_cnt[i]) begin
                cnt <= '0;
                if (tmr != '0) tmr <= tmr - 1'b1;
            end else if (abort_nxt[i]) begin
                cnt <= cnt_n;
                tmr <= load;
            end else if (tmr != '0) begin
                tmr <= tmr - 1'b1;
            end
        end
    end
endmodule

// File: rtl/txn_arbiter.sv
// Top of the transactional conflict arbiter: request/decision ports,
// starvation tracking, commit token and back-off. Assumes holder data is
// valid in the same cycle as the request.
module txn_arbiter
    import txn_arb_pkg::*;
#(
    parameter int N_TXN        = 4,
    parameter int TS_W         = 16,
    parameter int STARVE_LIMIT = 256,
    parameter int BACKOFF_BASE = 4,
    parameter int MAX_EXP      = 8,
    parameter int PIN_ABORTS   = 3,
    localparam int ID_W = $clog2(N_TXN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ID_W-1:0]       req_id,
    input  logic [TS_W-1:0]       req_ts,
    input  logic                  req_wr,
    input  logic [N_TXN-1:0]      holder_valid,
    input  logic [N_TXN-1:0]      holder_wr,
    input  logic [N_TXN*TS_W-1:0] holder_ts,
    output logic                  dec_valid,
    output logic [1:0]            dec_kind,
    output logic [ID_W-1:0]       dec_id,
    output logic [N_TXN-1:0]      dec_abort,
    output logic [N_TXN-1:0]      txn_abort,
    input  logic [N_TXN-1:0]      commit_req,
    input  logic [N_TXN-1:0]      commit_done,
    input  logic [N_TXN-1:0]      commit_kill,
    output logic [N_TXN-1:0]      token_grant,
    output logic [N_TXN-1:0]      backoff_active
);
    logic             acc;
    dec_kind_e        pol_kind;
    logic [N_TXN-1:0] pol_mask, waiting, starved, pinned, kill, done_vec, abort_nxt;

    assign req_ready = !backoff_active[req_id];
    assign acc       = req_valid && req_ready;
    assign abort_nxt = (acc ? pol_mask : '0) | kill;

    txn_conflict_policy #(.N_TXN(N_TXN), .TS_W(TS_W)) u_policy (
        .hv(holder_valid), .hw(holder_wr), .hts(holder_ts),
        .req_id(req_id), .req_ts(req_ts), .req_wr(req_wr),
        .waiting(waiting), .starved(starved[req_id]),
        .kind(pol_kind), .mask(pol_mask)
    );

    txn_starve_monitor #(.N_TXN(N_TXN), .STARVE_LIMIT(STARVE_LIMIT)) u_starve (
        .clk(clk), .rst_n(rst_n), .acc(acc), .req_id(req_id), .req_wr(req_wr),
        .kind(pol_kind), .abort_nxt(abort_nxt), .waiting(waiting), .starved(starved)
    );

    txn_commit_token #(.N_TXN(N_TXN)) u_token (
        .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .commit_done(commit_done),
        .commit_kill(commit_kill), .pinned(pinned), .owner(token_grant),
        .kill(kill), .done_vec(done_vec)
    );

    txn_backoff #(.N_TXN(N_TXN), .BACKOFF_BASE(BACKOFF_BASE), .MAX_EXP(MAX_EXP),
                  .PIN_ABORTS(PIN_ABORTS)) u_backoff (
        .clk(clk), .rst_n(rst_n), .abort_nxt(abort_nxt), .clr_cnt(done_vec),
        .active(backoff_active), .pinned(pinned)
    );

    // Register the decision and the abort pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_kind  <= DEC_GRANT;
            dec_id    <= '0;
            dec_abort <= '0;
            txn_abort <= '0;
        end else begin
            dec_valid <= acc;
            dec_kind  <= pol_kind;
            dec_id    <= req_id;
            dec_abort <= acc ? pol_mask : '0;
            txn_abort <= abort_nxt;
        end
    end
endmodule

// File: rtl/txn_arbiter_chk.sv
// Port-level properties of the arbiter, attached by bind.
module txn_arbiter_chk #(
    parameter int N_TXN = 4,
    localparam int ID_W = $clog2(N_TXN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [ID_W-1:0]  req_id,
    input logic             dec_valid,
    input logic [1:0]       dec_kind,
    input logic [ID_W-1:0]  dec_id,
    input logic [N_TXN-1:0] dec_abort,
    input logic [N_TXN-1:0] txn_abort,
    input logic [N_TXN-1:0] token_grant,
    input logic [N_TXN-1:0] commit_done,
    input logic [N_TXN-1:0] backoff_active
);
    p_decision_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(req_valid && req_ready));
    p_decision_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_id == $past(req_id)));
    p_grant_spares_self_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_kind == 2'd0) |-> !dec_abort[dec_id]);
    p_self_abort_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_kind == 2'd2) |-> (dec_abort == (N_TXN'(1) << dec_id)));
    p_token_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(token_grant));
    p_token_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|token_grant) && !(|(commit_done & token_grant))) |=> (token_grant == $past(token_grant)));
    p_abort_opens_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|txn_abort) |-> ((txn_abort & ~backoff_active) == '0));
endmodule

bind txn_arbiter txn_arbiter_chk #(.N_TXN(N_TXN)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .dec_valid(dec_valid), .dec_kind(dec_kind), .dec_id(dec_id),
    .dec_abort(dec_abort), .txn_abort(txn_abort), .token_grant(token_grant),
    .commit_done(commit_done), .backoff_active(backoff_active)
);

// File: tb/txn_arbiter_tb.sv
// Self-checking bench: vector table for the policy, then directed tests.
module txn_arbiter_tb;
    localparam int N = 4, TS_W = 16, LIMIT = 8, BASE = 2, PIN = 2;

    typedef struct packed {
        logic [3:0]  hv;
        logic [3:0]  hw;
        logic [1:0]  id;
        logic [15:0] ts;
        logic        wr;
        logic [1:0]  kind;
        logic [3:0]  mask;
    } vec_t;

    // Age stamps: T0=10, T1=20, T2=30, T3=40. kind 0 grant, 1 stall.
    localparam vec_t VECS [9] = '{
        '{4'b0000, 4'b0000, 2'd0, 16'd10, 1'b1, 2'd0, 4'b0000}, // R1 empty
        '{4'b0110, 4'b0000, 2'd0, 16'd10, 1'b0, 2'd0, 4'b0000}, // R1 readers share
        '{4'b0110, 4'b0100, 2'd3, 16'd40, 1'b0, 2'd1, 4'b0000}, // R2 younger stalls
        '{4'b0110, 4'b0100, 2'd0, 16'd10, 1'b0, 2'd0, 4'b0100}, // R2 older wins
        '{4'b0011, 4'b0000, 2'd3, 16'd40, 1'b1, 2'd1, 4'b0000}, // R2 writer younger
        '{4'b1010, 4'b0000, 2'd0, 16'd10, 1'b1, 2'd0, 4'b1010}, // R2 writer older
        '{4'b0101, 4'b0000, 2'd2, 16'd30, 1'b1, 2'd1, 4'b0000}, // R1 self excluded
        '{4'b0110, 4'b0000, 2'd1, 16'd20, 1'b1, 2'd0, 4'b0100}, // R1 upgrade self excl
        '{4'b0100, 4'b0100, 2'd0, 16'd30, 1'b1, 2'd1, 4'b0000}  // R2 tie stalls
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_wr = 1'b0, req_ready;
    logic [1:0] req_id = '0;
    logic [15:0] req_ts = '0;
    logic [3:0] holder_valid = '0, holder_wr = '0;
    logic [63:0] holder_ts = {16'd40, 16'd30, 16'd20, 16'd10};
    logic dec_valid;
    logic [1:0] dec_kind, dec_id;
    logic [3:0] dec_abort, txn_abort, token_grant, backoff_active;
    logic [3:0] commit_req = '0, commit_done = '0, commit_kill = '0;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    txn_arbiter #(.N_TXN(N), .TS_W(TS_W), .STARVE_LIMIT(LIMIT), .BACKOFF_BASE(BASE),
                  .MAX_EXP(8), .PIN_ABORTS(PIN)) u_dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0; commit_req = '0; commit_done = '0; commit_kill = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Issue a request at a negedge; sample the decision one cycle later.
    task automatic do_req(input logic [1:0] id, input logic [15:0] ts, input logic wr,
                          output logic [1:0] kind, output logic [3:0] mask);
        req_id = id; req_ts = ts; req_wr = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 dec_valid", int'(dec_valid), 1);
        chk("R3 dec_id", int'(dec_id), int'(id));
        kind = dec_kind; mask = dec_abort;
    endtask

    // Count cycles the back-off window of one transaction stays open.
    task automatic window(input int idx, output int n);
        n = 0;
        while (backoff_active[idx] && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic chk_range(input string tag, input int v, input int lo, input int hi);
        n_chk++;
        if (v < lo || v > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, v, lo, hi);
        end
    endtask

    initial begin
        logic [1:0] k;
        logic [3:0] m;
        int w;

        // Vector table for the conflict policy.
        for (int v = 0; v < 9; v++) begin
            do_reset();
            holder_valid = VECS[v].hv; holder_wr = VECS[v].hw;
            do_req(VECS[v].id, VECS[v].ts, VECS[v].wr, k, m);
            chk($sformatf("R2 vec%0d kind", v), int'(k), int'(VECS[v].kind));
            chk($sformatf("R2 vec%0d mask", v), int'(m), int'(VECS[v].mask));
        end

        // R10 reset state.
        do_reset();
        @(negedge clk);
        chk("R10 dec_valid", int'(dec_valid), 0);
        chk("R10 txn_abort", int'(txn_abort), 0);
        chk("R10 token", int'(token_grant), 0);
        chk("R10 backoff", int'(backoff_active), 0);
        chk("R10 ready", int'(req_ready), 1);

        // R4 starving writer: T2 waits behind readers, new reader joins.
        holder_valid = 4'b0001; holder_wr = 4'b0000;
        do_req(2'd2, 16'd30, 1'b1, k, m);
        chk("R4 first stall", int'(k), 1);
        repeat (2) @(negedge clk);
        do_req(2'd2, 16'd30, 1'b1, k, m);
        chk("R4 stall before alarm", int'(k), 1);
        holder_valid = 4'b0011;
        repeat (12) @(negedge clk);
        do_req(2'd2, 16'd30, 1'b1, k, m);
        chk("R4 override kind", int'(k), 0);
        chk("R4 override mask", int'(m), 4'b0011);
        chk("R7 abort pulse readers", int'(txn_abort), 4'b0011);
        do_req(2'd2, 16'd30, 1'b1, k, m);
        chk("R4 alarm cleared", int'(k), 1);
        chk("R4 alarm cleared mask", int'(m), 0);

        // R5 dueling: requester older than a waiting upgrader.
        do_reset();
        holder_valid = 4'b0101; holder_wr = 4'b0000;
        do_req(2'd2, 16'd30, 1'b1, k, m);
        chk("R5 T2 stalls", int'(k), 1);
        holder_valid = 4'b0111;
        do_req(2'd1, 16'd20, 1'b1, k, m);
        chk("R5 older upgrader kind", int'(k), 1);
        chk("R5 younger upgrader aborted", int'(m), 4'b0100);

        // R5 dueling: requester younger than a waiting upgrader.
        do_reset();
        holder_valid = 4'b0111; holder_wr = 4'b0000;
        do_req(2'd1, 16'd20, 1'b1, k, m);
        chk("R5 T1 stalls", int'(k), 1);
        do_req(2'd2, 16'd30, 1'b1, k, m);
        chk("R5 younger self-abort kind", int'(k), 2);
        chk("R5 self-abort mask", int'(m), 4'b0100);
        chk("R7 self-abort pulse", int'(txn_abort), 4'b0100);
        req_id = 2'd2;
        #0.1;
        chk("R3 ready low in backoff", int'(req_ready), 0);
        window(2, w);
        chk_range("R9 window after 1 abort", w, BASE * 2, BASE * 2 + 15);
        chk("R3 ready after backoff", int'(req_ready), 1);

        // R6/R7 commit token.
        commit_req = 4'b0011;
        @(negedge clk);
        chk("R6 lowest index owner", int'(token_grant), 4'b0001);
        commit_req = 4'b0010;
        commit_done = 4'b1000; commit_kill = 4'b1111;
        @(negedge clk);
        commit_done = '0; commit_kill = '0;
        chk("R6 non-owner done ignored", int'(token_grant), 4'b0001);
        chk("R6 non-owner no abort", int'(txn_abort), 0);
        commit_done = 4'b0001; commit_kill = 4'b0111;
        @(negedge clk);
        commit_done = '0; commit_kill = '0;
        chk("R7 committer kills others", int'(txn_abort), 4'b0110);
        chk("R6 released", int'(token_grant), 0);
        window(2, w);
        chk_range("R9 window after 2 aborts", w, BASE * 4, BASE * 4 + 15);
        chk("R6 next owner", int'(token_grant), 4'b0010);

        // R8 pinned priority: T2 (2 aborts) beats T0 (lower index, 0 aborts).
        commit_req = 4'b0101; commit_done = 4'b0010;
        @(negedge clk);
        commit_done = '0;
        @(negedge clk);
        chk("R8 pinned takes token", int'(token_grant), 4'b0100);

        // R9 count reset by commit: T2 commits, later aborted once more.
        commit_req = 4'b0001; commit_done = 4'b0100;
        @(negedge clk);
        commit_done = '0;
        @(negedge clk);
        chk("R6 T0 owner", int'(token_grant), 4'b0001);
        commit_req = '0; commit_done = 4'b0001; commit_kill = 4'b0100;
        @(negedge clk);
        commit_done = '0; commit_kill = '0;
        chk("R7 kill after reset count", int'(txn_abort), 4'b0100);
        window(2, w);
        chk_range("R9 window reset by commit", w, BASE * 2, BASE * 2 + 15);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule